// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects up to eight interrupt request lines and presents a single interrupt line to a processor. Software programs it through a small register port with one select bit. A start word opens a configuration sequence that ends in a running state. Once running, further words set the mask, retire in-service levels, rotate priority and choose what a read returns. The controller records pending requests, remembers which levels are being serviced and raises `irq_out` only when an unmasked request outranks everything in service. The request input of each line is either edge-latched or level-following.

The processor answers `irq_out` with two one-cycle pulses on `ack_pulse`. The first pulse freezes the winning level and marks it in service. The second pulse places the type number on `rdata`. The type number is five programmed high bits followed by the three-bit level. An input that the configuration marks as fed by a subordinate controller also puts its level on a cascade output between the two pulses. The acknowledge is a pulse handshake and has no back-pressure. If no request qualifies at the first pulse, level 7 is returned and nothing is marked in service.

Top module: `irq_ctl8`

## Requirements
- R1: A write with `reg_sel`=0 and bit 4 set starts configuration. Bit 0 requests an options word, bit 1 set means a single controller, and bit 3 set selects level inputs. The next `reg_sel`=1 write loads the type base. For a single controller with no options word, the write after that loads the mask, which a `reg_sel`=1 read returns.
- R2: When bit 1 of the start word is clear, the write after the base loads the subordinate map, not the mask. When bit 0 is also set, the next write loads the options word.
- R3: The second acknowledge pulse puts {base bits 7..3, level} on `rdata` in the following cycle.
- R4: A mask bit of 1 keeps its input from raising `irq_out`. With all requests pending, `irq_out` is high unless the mask is 8'hFF.
- R5: In fixed order, level 0 has the highest priority and level 7 the lowest. The acknowledged level is the highest-priority unmasked pending request.
- R6: `irq_out` is high only when an unmasked pending request outranks every level in service.
- R7: In edge mode, a rising input sets its request bit, which stays set until acknowledged. An input held high after acknowledge makes no new request.
- R8: In level mode, the request bit follows the input. If the input drops before acknowledge, `irq_out` falls.
- R9: The first acknowledge pulse sets the winner's in-service bit and clears its edge request. Writing 8'h0A and then reading with `reg_sel`=0 returns the request register. Writing 8'h0B first returns the in-service register.
- R10: Writing 8'h20 clears the highest-priority in-service bit and leaves the priority order unchanged.
- R11: Writing 8'hA0 clears the highest-priority in-service bit and makes that level the lowest. The level after it becomes the highest.
- R12: When bit 1 of the options word is set, the in-service bit is cleared at the second acknowledge pulse with no end command.
- R13: Until configuration completes, `irq_out` stays low. A start word clears the mask, the in-service bits and the edge requests.
- R14: At the first acknowledge of a level marked in the subordinate map, `cas_en` rises and `cas_o` holds that level until the second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register port select |
| wr | input | 1 | Write strobe, qualified by `sel` |
| rd | input | 1 | Read strobe, qualified by `sel` |
| reg_sel | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or type number, registered |
| irq_in | input | 8 | Interrupt request lines |
| ack_pulse | input | 1 | Acknowledge pulse from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| cas_en | output | 1 | Cascade address valid |
| cas_o | output | 3 | Cascade address (serviced level) |

## Verification
Every register write takes effect at the clock edge where it is strobed and is visible one cycle later. A change on `irq_in` reaches `irq_out` one edge later through the request register. Read data and the type number appear on `rdata` the cycle after their strobe or second acknowledge pulse. The bench drives every stimulus on the falling edge and samples at the next falling edge, so each result is read exactly one register stage after its cause. The sweeps cover every nonzero request pattern, every mask value and every rotation base, against priorities computed in the bench.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_SLAVE,
    CFG_OPTS,
    CFG_RUN
  } cfg_state_e;

  localparam logic [2:0] EOI_PLAIN  = 3'b001;
  localparam logic [2:0] EOI_ROTATE = 3'b101;
endpackage

// File: rtl/irq_cfg.sv
module irq_cfg
  import irq_ctl_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LW = $clog2(N),
  localparam int BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          reg_sel,
  input  logic [DW-1:0] wdata,
  output logic          run,
  output logic          init_stb,
  output logic [BW-1:0] base,
  output logic          single,
  output logic          level_mode,
  output logic          auto_eoi,
  output logic [N-1:0]  slave_map,
  output logic [N-1:0]  mask,
  output logic          rd_isr,
  output logic          eoi_stb,
  output logic          eoi_rot
);
  cfg_state_e st;
  logic       wants_opts;
  logic       cmd_wr;

  assign run      = (st == CFG_RUN);
  assign init_stb = wr_stb && !reg_sel && wdata[4];
  assign cmd_wr   = wr_stb && !reg_sel && !wdata[4] && run;
  assign eoi_rot  = (wdata[7:5] == EOI_ROTATE);
  assign eoi_stb  = cmd_wr && !wdata[3] &&
                    ((wdata[7:5] == EOI_PLAIN) || eoi_rot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= CFG_IDLE;
      wants_opts <= 1'b0;
      base       <= '0;
      single     <= 1'b1;
      level_mode <= 1'b0;
      auto_eoi   <= 1'b0;
      slave_map  <= '0;
      mask       <= '0;
      rd_isr     <= 1'b0;
    end else if (init_stb) begin
      st         <= CFG_BASE;
      wants_opts <= wdata[0];
      single     <= wdata[1];
      level_mode <= wdata[3];
      auto_eoi   <= 1'b0;
      slave_map  <= '0;
      mask       <= '0;
      rd_isr     <= 1'b0;
    end else if (wr_stb && reg_sel) begin
      case (st)
        CFG_BASE: begin
          base <= wdata[DW-1:LW];
          if (!single)        st <= CFG_SLAVE;
          else if (wants_opts) st <= CFG_OPTS;
          else                 st <= CFG_RUN;
        end
        CFG_SLAVE: begin
          slave_map <= wdata[N-1:0];
          st <= wants_opts ? CFG_OPTS : CFG_RUN;
        end
        CFG_OPTS: begin
          auto_eoi <= wdata[1];
          st       <= CFG_RUN;
        end
        CFG_RUN:  mask <= wdata[N-1:0];
        default:  ;
      endcase
    end else if (cmd_wr && wdata[3] && wdata[1]) begin
      rd_isr <= wdata[0];
    end
  end
endmodule

// File: rtl/irq_req.sv
module irq_req #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          level_mode,
  input  logic          clr_all,
  input  logic          clr_stb,
  input  logic [LW-1:0] clr_lvl,
  output logic [N-1:0]  irr
);
  logic [N-1:0] irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq_in;
      for (int i = 0; i < N; i++) begin
        if (level_mode)                    irr[i] <= irq_in[i];
        else if (clr_all)                  irr[i] <= 1'b0;
        else if (irq_in[i] && !irq_q[i])   irr[i] <= 1'b1;
        else if (clr_stb && clr_lvl == LW'(i)) irr[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  isr,
  input  logic [LW-1:0] lo,
  output logic          req_any,
  output logic [LW-1:0] req_lvl,
  output logic          isr_any,
  output logic [LW-1:0] isr_lvl,
  output logic          fire
);
  logic [LW-1:0] lv;
  logic [LW-1:0] req_rank;
  logic [LW-1:0] isr_rank;

  always_comb begin
    req_any  = 1'b0;
    req_lvl  = '0;
    req_rank = '0;
    isr_any  = 1'b0;
    isr_lvl  = '0;
    isr_rank = '0;
    lv       = '0;
    for (int k = N - 1; k >= 0; k--) begin
      lv = lo + LW'(1) + LW'(k);
      if (req[lv]) begin
        req_any  = 1'b1;
        req_lvl  = lv;
        req_rank = LW'(k);
      end
      if (isr[lv]) begin
        isr_any  = 1'b1;
        isr_lvl  = lv;
        isr_rank = LW'(k);
      end
    end
    fire = req_any && (!isr_any || (req_rank < isr_rank));
  end
endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8 #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LW = $clog2(N),
  localparam int BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic          rd,
  input  logic          reg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [N-1:0]  irq_in,
  input  logic          ack_pulse,
  output logic          irq_out,
  output logic          cas_en,
  output logic [LW-1:0] cas_o
);
  logic          wr_stb, rd_stb;
  logic          run, init_stb, single, level_mode, auto_eoi, rd_isr;
  logic          eoi_stb, eoi_rot;
  logic [BW-1:0] base;
  logic [N-1:0]  slave_map, mask, irr, isr, req_eff;
  logic          req_any, isr_any, fire;
  logic [LW-1:0] req_lvl, isr_lvl, lo, held;
  logic          held_ok, second;
  logic          ack_first, ack_second, take;

  assign wr_stb     = sel && wr;
  assign rd_stb     = sel && rd;
  assign ack_first  = ack_pulse && !second;
  assign ack_second = ack_pulse && second;
  assign req_eff    = irr & ~mask;
  assign take       = ack_first && run && fire;
  assign irq_out    = run && !second && fire;

  irq_cfg #(.N(N), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .reg_sel(reg_sel),
    .wdata(wdata), .run(run), .init_stb(init_stb), .base(base),
    .single(single), .level_mode(level_mode), .auto_eoi(auto_eoi),
    .slave_map(slave_map), .mask(mask), .rd_isr(rd_isr),
    .eoi_stb(eoi_stb), .eoi_rot(eoi_rot)
  );

  irq_req #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .clr_all(init_stb), .clr_stb(take), .clr_lvl(req_lvl), .irr(irr)
  );

  irq_prio #(.N(N)) u_prio (
    .req(req_eff), .isr(isr), .lo(lo), .req_any(req_any),
    .req_lvl(req_lvl), .isr_any(isr_any), .isr_lvl(isr_lvl), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr     <= '0;
      lo      <= LW'(N - 1);
      held    <= '0;
      held_ok <= 1'b0;
      second  <= 1'b0;
      cas_en  <= 1'b0;
      cas_o   <= '0;
    end else if (init_stb) begin
      isr     <= '0;
      lo      <= LW'(N - 1);
      held_ok <= 1'b0;
      second  <= 1'b0;
      cas_en  <= 1'b0;
      cas_o   <= '0;
    end else if (ack_first) begin
      second <= 1'b1;
      if (take) begin
        isr[req_lvl] <= 1'b1;
        held         <= req_lvl;
        held_ok      <= 1'b1;
        if (!single && slave_map[req_lvl]) begin
          cas_en <= 1'b1;
          cas_o  <= req_lvl;
        end
      end else begin
        held    <= LW'(N - 1);
        held_ok <= 1'b0;
      end
    end else if (ack_second) begin
      second <= 1'b0;
      cas_en <= 1'b0;
      cas_o  <= '0;
      if (auto_eoi && held_ok) isr[held] <= 1'b0;
    end else if (eoi_stb && isr_any) begin
      isr[isr_lvl] <= 1'b0;
      if (eoi_rot) lo <= isr_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (ack_second) rdata <= {base, held};
    else if (rd_stb) begin
      if (reg_sel)       rdata <= DW'(mask);
      else if (rd_isr)   rdata <= DW'(isr);
      else               rdata <= DW'(irr);
    end
  end
endmodule

// File: rtl/irq_ctl8_chk.sv
module irq_ctl8_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack_pulse,
  input logic         irq_out,
  input logic         cas_en,
  input logic         run,
  input logic         second,
  input logic         eoi_stb,
  input logic [N-1:0] irr,
  input logic [N-1:0] mask,
  input logic [N-1:0] isr
);
  // R13
  quiet_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !irq_out);

  // R4
  masked_no_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(irr & ~mask));

  // R9
  isr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !second) |=> ($countones(isr) <= $countones($past(isr)) + 1));

  // R10
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb && !ack_pulse && (|isr)) |=> ($countones(isr) + 1 == $countones($past(isr))));

  // R14
  cas_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_en) |-> $past(ack_pulse));
endmodule

bind irq_ctl8 irq_ctl8_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_pulse(ack_pulse), .irq_out(irq_out),
  .cas_en(cas_en), .run(run), .second(second), .eoi_stb(eoi_stb),
  .irr(irr), .mask(mask), .isr(isr)
);

// File: tb/sim_irq_ctl8.sv
module sim_irq_ctl8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, reg_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       ack_pulse = 1'b0;
  logic       irq_out, cas_en;
  logic [2:0] cas_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_ctl8 u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .ack_pulse(ack_pulse),
    .irq_out(irq_out), .cas_en(cas_en), .cas_o(cas_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; reg_sel = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] v);
    sel = 1'b1; rd = 1'b1; reg_sel = a;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
    v = rdata;
  endtask

  task automatic ack;
    ack_pulse = 1'b1;
    @(negedge clk);
    ack_pulse = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic logic [2:0] first_bit(input logic [7:0] v, input int start);
    for (int k = 0; k < 8; k++)
      if (v[(start + k) % 8]) return 3'((start + k) % 8);
    return 3'd7;
  endfunction

  initial begin
    logic [7:0] v;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    chk("R13 reset irq_out", {7'd0, irq_out}, 8'h00);
    chk("R14 reset cas_en", {7'd0, cas_en}, 8'h00);
    chk("R3 reset rdata", rdata, 8'h00);

    // R1: single controller, no options word
    bus_wr(0, 8'h12); bus_wr(1, 8'h08); bus_wr(1, 8'h5A);
    bus_rd(1, v); chk("R1 mask after short sequence", v, 8'h5A);

    // R13 + R12: edge mode, auto end of interrupt
    bus_wr(0, 8'h13);
    bus_rd(1, v); chk("R13 start word clears mask", v, 8'h00);
    irq_in = 8'h20; tick;
    chk("R13 no irq before run", {7'd0, irq_out}, 8'h00);
    bus_wr(1, 8'h48); bus_wr(1, 8'h03);
    chk("R13 latched edge raises irq after run", {7'd0, irq_out}, 8'h01);
    ack; ack;
    chk("R3 type number auto mode", rdata, 8'h4D);
    bus_wr(0, 8'h0B); bus_rd(0, v);
    chk("R12 in-service cleared by auto end", v, 8'h00);
    irq_in = 8'h00; tick;

    // R7 + R9 + R3: edge mode, explicit end
    bus_wr(0, 8'h13); bus_wr(1, 8'h48); bus_wr(1, 8'h01);
    irq_in = 8'h04; tick;
    chk("R7 edge raises irq", {7'd0, irq_out}, 8'h01);
    bus_wr(0, 8'h0A); bus_rd(0, v); chk("R7 request latched", v, 8'h04);
    ack;
    bus_rd(0, v); chk("R9 request cleared by first ack", v, 8'h00);
    bus_wr(0, 8'h0B); bus_rd(0, v); chk("R9 in-service set by first ack", v, 8'h04);
    ack;
    chk("R3 type number", rdata, 8'h4A);
    chk("R7 held input no new request", {7'd0, irq_out}, 8'h00);
    bus_wr(0, 8'h20);
    bus_rd(0, v); chk("R10 end clears in-service", v, 8'h00);
    chk("R7 held input still quiet", {7'd0, irq_out}, 8'h00);
    irq_in = 8'h00; tick; irq_in = 8'h04; tick;
    chk("R7 new edge raises irq", {7'd0, irq_out}, 8'h01);
    ack; ack; bus_wr(0, 8'h20);
    irq_in = 8'h00; tick;

    // R2 + R14: cascade arrangement
    bus_wr(0, 8'h11); bus_wr(1, 8'h20); bus_wr(1, 8'h80);
    bus_rd(1, v); chk("R2 third word went to subordinate map", v, 8'h00);
    bus_wr(1, 8'h01);
    bus_wr(1, 8'h00);
    irq_in = 8'h80; tick;
    ack;
    chk("R14 cas_en on mapped level", {7'd0, cas_en}, 8'h01);
    chk("R14 cas_o level", {5'd0, cas_o}, 8'h07);
    ack;
    chk("R14 cas_en drops", {7'd0, cas_en}, 8'h00);
    chk("R3 cascade type number", rdata, 8'h27);
    bus_wr(0, 8'h20);
    irq_in = 8'h88; tick;
    ack;
    chk("R14 unmapped level no cas", {7'd0, cas_en}, 8'h00);
    ack;
    chk("R5 level 3 type", rdata, 8'h23);
    bus_wr(0, 8'h20);
    irq_in = 8'h00; tick;

    // level mode sweeps
    bus_wr(0, 8'h1B); bus_wr(1, 8'hF0); bus_wr(1, 8'h01);
    irq_in = 8'h10; tick;
    chk("R8 level raises irq", {7'd0, irq_out}, 8'h01);
    irq_in = 8'h00; tick;
    chk("R8 level drop clears irq", {7'd0, irq_out}, 8'h00);

    for (int p = 1; p < 256; p++) begin
      irq_in = 8'(p); tick;
      chk("R5 pending raises irq", {7'd0, irq_out}, 8'h01);
      ack; ack;
      chk("R5 winner type", rdata, {5'b11110, first_bit(8'(p), 0)});
      chk("R6 lower levels blocked", {7'd0, irq_out}, 8'h00);
      bus_wr(0, 8'h20);
      chk("R10 end reopens irq", {7'd0, irq_out}, 8'h01);
      irq_in = 8'h00; tick;
    end

    for (int l = 0; l < 8; l++) begin
      irq_in = 8'(1 << l); tick;
      ack; ack;
      bus_wr(0, 8'hA0);
      irq_in = 8'hFF; tick;
      ack; ack;
      chk("R11 rotated winner", rdata, {5'b11110, first_bit(8'hFF, (l + 1) % 8)});
      bus_wr(0, 8'h20);
      irq_in = 8'h00; tick;
    end

    irq_in = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      bus_wr(1, 8'(m));
      chk("R4 mask gates irq", {7'd0, irq_out}, (m == 255) ? 8'h00 : 8'h01);
      bus_rd(1, v); chk("R4 mask readback", v, 8'(m));
    end
    irq_in = 8'h00; tick;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule